// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block is a small power-state controller clocked from the always-on slow clock (nominally 32.768 kHz). Software sends a hibernate command over a 32-bit register bus, and the block then drops the system power-enable output. Power stays off until the wakeup pin has been held asserted for a programmed number of slow-clock ticks without a break. A short pulse on the pin does not wake the system.

After a qualified wakeup, power-enable rises and the system reset output is held low for a second programmed number of ticks. It is then released and the block returns to its normal running state. Both durations are stored in masked register fields whose value counts ticks directly. At 32.768 kHz the filter field covers roughly zero to two seconds and the reset field covers roughly zero to 125 ms. Typical settings are about 100 ms and 60 ms.

The wakeup pin is active low by default and passes through a synchronizer of configurable depth before it is used. Regulator control and generation of the clock are outside this block.

Top module: `pwr_wake_seq`

## Requirements
- R1: After reset, `pwr_en` is 1, `sys_rst_n` is 1, and the wakeup-filter and reset-length registers both read back as zero.
- R2: A write to offset 0x20 with data bit 0 set, made while running, drives `pwr_en` low from the next clock edge. A write to 0x20 with bit 0 clear has no effect.
- R3: The wakeup-filter register at offset 0x24 keeps only data bits 15:5, and every other bit reads as 0. Reads at offsets 0x20, 0x2C and any other unmapped offset return 0.
- R4: The reset-length register at offset 0x28 keeps only data bits 11:5, and every other bit reads as 0.
- R5: Let F be the value read from 0x24, with F=0 treated as 1, and let S be the synchronizer depth. When the active-low wakeup pin is sampled low on F consecutive edges, `pwr_en` rises S+F edges after the first low sample.
- R6: If the pin returns high before the count completes, the count restarts, and the next wakeup needs a full uninterrupted run of F low samples.
- R7: If the pin is already low when hibernation starts, it must be seen high at least once before low samples count toward a wakeup.
- R8: When `pwr_en` rises, `sys_rst_n` goes low in the same cycle and stays low for exactly R cycles, with R taken from 0x28 and R=0 treated as 1. It is then released and the block is running again.
- R9: `pwr_en` and `sys_rst_n` are never low together, and a hibernate command written during the reset pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Active-low power-on reset of the controller |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational from `bus_addr` |
| wake_pin | input | 1 | Wakeup pin, active low by default |
| pwr_en | output | 1 | System power enable, low while hibernating |
| sys_rst_n | output | 1 | System reset, low during the post-wakeup pulse |

## Verification
The filter count can reach its threshold in the same cycle that the pin deasserts. The bench provokes this by holding the pin low for exactly F-1 samples and then releasing it, and it expects no wakeup. It then holds the pin low for exactly F samples and expects `pwr_en` to rise on the predicted edge. A second collision is a hibernate command written while the reset pulse is running: the bench writes it during the pulse and checks that power stays enabled after the release.

// File: rtl/hseq_pkg.sv
package hseq_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HIB  = 2'd1,
      ST_PULS = 2'd2
   } hseq_state_e;

   localparam int unsigned OFS_HIB  = 'h20;
   localparam int unsigned OFS_FILT = 'h24;
   localparam int unsigned OFS_RLEN = 'h28;
endpackage

// File: rtl/hseq_regs.sv
module hseq_regs
   import hseq_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int F_LSB  = 5,
   parameter int F_MSB  = 15,
   parameter int R_LSB  = 5,
   parameter int R_MSB  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [F_MSB:0]    filt_ticks,
   output logic [R_MSB:0]    rlen_ticks,
   output logic              hib_req
);
   localparam logic [ADDR_W-1:0] A_HIB  = ADDR_W'(OFS_HIB);
   localparam logic [ADDR_W-1:0] A_FILT = ADDR_W'(OFS_FILT);
   localparam logic [ADDR_W-1:0] A_RLEN = ADDR_W'(OFS_RLEN);

   logic [F_MSB:F_LSB] filt_q;
   logic [R_MSB:R_LSB] rlen_q;
   logic               unused_wbits;

   assign unused_wbits = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= '0;
         rlen_q <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_FILT) filt_q <= bus_wdata[F_MSB:F_LSB];
         if (bus_addr == A_RLEN) rlen_q <= bus_wdata[R_MSB:R_LSB];
      end
   end

   assign hib_req = bus_wr && (bus_addr == A_HIB) && bus_wdata[0];

   always_comb begin
      filt_ticks = '0;
      filt_ticks[F_MSB:F_LSB] = filt_q;
      rlen_ticks = '0;
      rlen_ticks[R_MSB:R_LSB] = rlen_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_FILT) bus_rdata[F_MSB:F_LSB] = filt_q;
      else if (bus_addr == A_RLEN) bus_rdata[R_MSB:R_LSB] = rlen_q;
   end
endmodule

// File: rtl/hseq_tick_cnt.sv
module hseq_tick_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] limit,
   output logic         done
);
   logic [W-1:0] cnt_q;
   logic [W:0]   cnt_nxt;

   assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
   assign done    = en && (cnt_nxt >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!en || done)  cnt_q <= '0;
      else                   cnt_q <= cnt_nxt[W-1:0];
   end
endmodule

// File: rtl/hseq_fsm.sv
module hseq_fsm
   import hseq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hib_req,
   input  logic wake_act,
   input  logic filt_done,
   input  logic rlen_done,
   output logic filt_en,
   output logic rlen_en,
   output logic pwr_en,
   output logic sys_rst_n
);
   hseq_state_e state_q;
   logic        armed_q;

   assign filt_en   = (state_q == ST_HIB) && armed_q && wake_act;
   assign rlen_en   = (state_q == ST_PULS);
   assign pwr_en    = (state_q != ST_HIB);
   assign sys_rst_n = (state_q != ST_PULS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         armed_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               armed_q <= 1'b0;
               if (hib_req) state_q <= ST_HIB;
            end
            ST_HIB: begin
               if (!wake_act) armed_q <= 1'b1;
               if (filt_done) state_q <= ST_PULS;
            end
            ST_PULS: begin
               armed_q <= 1'b0;
               if (rlen_done) state_q <= ST_RUN;
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end
endmodule

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq #(
   parameter int ADDR_W       = 6,
   parameter int DATA_W       = 32,
   parameter int F_LSB        = 5,
   parameter int F_MSB        = 15,
   parameter int R_LSB        = 5,
   parameter int R_MSB        = 11,
   parameter int SYNC_STAGES  = 2,
   parameter bit WAKE_ACT_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              wake_pin,
   output logic              pwr_en,
   output logic              sys_rst_n
);
   localparam int FW = F_MSB + 1;
   localparam int RW = R_MSB + 1;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too small for the register offsets");
   end
   if (F_MSB >= DATA_W || R_MSB >= DATA_W) begin : g_bad_field
      $error("tick field exceeds the data width");
   end
   if (F_LSB > F_MSB || R_LSB > R_MSB) begin : g_bad_lsb
      $error("tick field bounds reversed");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES out of range");
   end

   logic [FW-1:0] filt_ticks;
   logic [RW-1:0] rlen_ticks;
   logic          hib_req;
   logic          wake_raw;
   logic          wake_act;
   logic          filt_en, filt_done;
   logic          rlen_en, rlen_done;

   if (WAKE_ACT_LOW) begin : g_pol_low
      assign wake_raw = ~wake_pin;
   end else begin : g_pol_high
      assign wake_raw = wake_pin;
   end

   if (SYNC_STAGES == 0) begin : g_nosync
      assign wake_act = wake_raw;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= '0;
         end else begin
            sync_q[0] <= wake_raw;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
         end
      end
      assign wake_act = sync_q[SYNC_STAGES-1];
   end

   hseq_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .F_LSB(F_LSB), .F_MSB(F_MSB), .R_LSB(R_LSB), .R_MSB(R_MSB)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .filt_ticks(filt_ticks), .rlen_ticks(rlen_ticks), .hib_req(hib_req)
   );

   hseq_tick_cnt #(.W(FW)) u_filt_cnt (
      .clk(clk), .rst_n(rst_n), .en(filt_en), .limit(filt_ticks), .done(filt_done)
   );

   hseq_tick_cnt #(.W(RW)) u_rlen_cnt (
      .clk(clk), .rst_n(rst_n), .en(rlen_en), .limit(rlen_ticks), .done(rlen_done)
   );

   hseq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .hib_req(hib_req), .wake_act(wake_act),
      .filt_done(filt_done), .rlen_done(rlen_done),
      .filt_en(filt_en), .rlen_en(rlen_en),
      .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
   );
endmodule

// File: rtl/pwr_wake_seq_chk.sv
module pwr_wake_seq_chk
   import hseq_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int F_LSB  = 5,
   parameter int F_MSB  = 15,
   parameter int R_LSB  = 5,
   parameter int R_MSB  = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              pwr_en,
   input logic              sys_rst_n
);
   localparam logic [ADDR_W-1:0] A_HIB  = ADDR_W'(OFS_HIB);
   localparam logic [ADDR_W-1:0] A_FILT = ADDR_W'(OFS_FILT);
   localparam logic [ADDR_W-1:0] A_RLEN = ADDR_W'(OFS_RLEN);
   localparam logic [DATA_W-1:0] M_FILT = ((DATA_W'(1) << (F_MSB + 1)) - 1) & ~((DATA_W'(1) << F_LSB) - 1);
   localparam logic [DATA_W-1:0] M_RLEN = ((DATA_W'(1) << (R_MSB + 1)) - 1) & ~((DATA_W'(1) << R_LSB) - 1);

   AST_HIB_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en) |-> $past(bus_wr && bus_addr == A_HIB && bus_wdata[0] && sys_rst_n)); // R2

   AST_FILT_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_FILT) |-> ((bus_rdata & ~M_FILT) == '0)); // R3

   AST_RLEN_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_RLEN) |-> ((bus_rdata & ~M_RLEN) == '0)); // R4

   AST_PULSE_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en) |-> !sys_rst_n); // R8

   AST_RELEASE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_n) |-> (pwr_en && $past(pwr_en))); // R8

   AST_NEVER_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en || sys_rst_n)); // R9

   AST_CMD_IGNORED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_HIB && !sys_rst_n) |=> pwr_en); // R9
endmodule

bind pwr_wake_seq pwr_wake_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .F_LSB(F_LSB), .F_MSB(F_MSB), .R_LSB(R_LSB), .R_MSB(R_MSB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
);

// File: tb/pwr_wake_seq_bench.sv
`timescale 1ns/1ps
module pwr_wake_seq_bench;
   localparam int AW = 6;
   localparam int DW = 32;
   localparam int S  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          wake_pin = 1'b1;
   logic          pwr_en, sys_rst_n;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pwr_wake_seq #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(S)) u_pwr_wake_seq (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_pin(wake_pin),
      .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
   );

   // filter write, reset-length write, expected F cycles, expected R cycles
   localparam int NV = 5;
   localparam int VEC [NV][4] = '{
      '{'h0040, 'h0020,   64,   32},
      '{'h0047, 'h001F,   64,    1},
      '{'h0000, 'h0000,    1,    1},
      '{'h00A0, 'hFFFF,  160, 4064},
      '{'h0020, 'h0060,   32,   96}
   };

   task automatic chk(input string req, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_write(input int a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic bus_read(input int a, output int d);
      bus_addr = AW'(a);
      #1;
      d = int'(bus_rdata);
      bus_addr = '0;
   endtask

   // pin low now; count negedges until pwr_en rises, then measure reset pulse
   task automatic wake_and_measure(output int n, output int m);
      wake_pin = 1'b0;
      n = 0;
      do begin
         @(negedge clk); n++;
      end while (!pwr_en && n < 70000);
      m = 0;
      while (!sys_rst_n && m < 70000) begin
         m++;
         @(negedge clk);
      end
      wake_pin = 1'b1;
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int d, n, m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pwr_en", pwr_en, 1);
      chk("R1 sys_rst_n", sys_rst_n, 1);
      bus_read('h24, d); chk("R1 filt reg", d, 0);
      bus_read('h28, d); chk("R1 rlen reg", d, 0);

      // R3 / R4 field masking and unmapped reads
      bus_write('h24, 32'hFFFF_FFFF);
      bus_read('h24, d); chk("R3 filt mask", d, 'h0000_FFE0);
      bus_write('h28, 32'hFFFF_FFFF);
      bus_read('h28, d); chk("R4 rlen mask", d, 'h0000_0FE0);
      bus_read('h2C, d); chk("R3 unmapped read", d, 0);
      bus_read('h20, d); chk("R3 hib reg read", d, 0);

      // R2 write of 0 to hibernate register does nothing
      bus_write('h20, 0);
      repeat (3) @(negedge clk);
      chk("R2 zero cmd ignored", pwr_en, 1);

      // vector table: R5 filter length, R8 pulse length
      for (int v = 0; v < NV; v++) begin
         bus_write('h24, VEC[v][0]);
         bus_write('h28, VEC[v][1]);
         bus_read('h24, d); chk("R3 filt readback", d, VEC[v][0] & 'hFFE0);
         bus_read('h28, d); chk("R4 rlen readback", d, VEC[v][1] & 'h0FE0);
         bus_write('h20, 1);
         chk("R2 hibernate entry", pwr_en, 0);
         repeat (4) @(negedge clk);
         wake_and_measure(n, m);
         chk("R5 wake delay", n, VEC[v][2] + S);
         chk("R8 pulse length", m, VEC[v][3]);
         chk("R8 running after pulse", {pwr_en, sys_rst_n}, 3);
      end

      // R6 release one sample short of threshold, then full run
      bus_write('h24, 64);
      bus_write('h28, 32);
      bus_write('h20, 1);
      repeat (4) @(negedge clk);
      wake_pin = 1'b0;
      repeat (63) @(negedge clk);
      wake_pin = 1'b1;
      repeat (8) @(negedge clk);
      chk("R6 short assertion no wake", pwr_en, 0);
      wake_and_measure(n, m);
      chk("R6 full restart count", n, 64 + S);

      // R7 pin low at entry must be released first
      wake_pin = 1'b0;
      bus_write('h20, 1);
      repeat (200) @(negedge clk);
      chk("R7 held pin no wake", pwr_en, 0);
      wake_pin = 1'b1;
      repeat (3) @(negedge clk);
      wake_and_measure(n, m);
      chk("R7 wake after release", n, 64 + S);

      // R9 hibernate command during reset pulse ignored
      bus_write('h28, 256);
      bus_write('h20, 1);
      repeat (4) @(negedge clk);
      wake_pin = 1'b0;
      while (pwr_en == 1'b0) @(negedge clk);
      wake_pin = 1'b1;
      chk("R9 pulse active", sys_rst_n, 0);
      bus_write('h20, 1);
      while (!sys_rst_n) @(negedge clk);
      repeat (5) @(negedge clk);
      chk("R9 cmd in pulse ignored", pwr_en, 1);
      chk("R9 released", sys_rst_n, 1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule